// File: doc/BRIEF.md
# SDRAM Command Decoder and Issue-Rule Checker

This block is a passive observer for the control pins of a four-bank, byte-wide synchronous DRAM. On every rising clock edge it samples the clock-enable, chip-select, the three command strobes, the data mask, the bank address and the address bus. It turns them into a command code, keeps an open/closed flag for every bank, and checks the sequencing rules the memory imposes. It never drives the memory. Any rule broken at an edge raises a one-cycle error pulse and sets a bit in a sticky error vector that only reset clears.

Internally a small sequencing state machine tracks three conditions. The first is the quiet window after a mode register write. The second is an auto-precharge burst in progress, whose length was captured at the last mode register write. The third is self refresh. Its states are `ST_READY` (no window open), `ST_MRS_WAIT` (counting the quiet cycles after a mode write), `ST_AP_BURST` (counting the remaining edges of an auto-precharge burst) and `ST_SELF_REF` (clock-enable held low after self refresh entry). The transitions are as follows:
- `ST_READY` goes to `ST_MRS_WAIT` on a mode write.
- `ST_READY` goes to `ST_SELF_REF` on self refresh entry.
- `ST_READY` goes to `ST_AP_BURST` on a read or write with auto-precharge when the burst is longer than one.
- `ST_MRS_WAIT` returns to `ST_READY` after its last quiet edge.
- `ST_AP_BURST` returns to `ST_READY` on its last burst edge or on a burst stop, and closes the bank.
- `ST_SELF_REF` returns to `ST_READY` on self refresh exit.

The block also provides the data-mask timing a controller needs. The write byte enable follows the mask in the same cycle. The read output enable follows the mask two edges later.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset: `cmd_q` = 0, `bank_open` = 0, `err_sticky` = 0, `err_pulse` = 0, `rd_oe` = 1. The burst length is 1.
- R2: The decode at an edge, with the clock-enable high at the previous edge, appears on `cmd_q` after that edge. Chip-select high gives 0 (no-op). With chip-select low, {ras_n,cas_n,we_n} decodes as follows: 000 gives 1 (mode write), 011 gives 5 (activate), 101 gives 6 (read), 100 gives 7 (write), 110 gives 8 (burst stop), 010 gives 9 (precharge one bank) and 111 gives 0.
- R3: Refresh (001) with the clock-enable high at the previous and current edge gives 2 (auto refresh). With the clock-enable falling it gives 3 (self refresh entry). At an edge whose previous clock-enable was low, the pins are ignored and the code is 11. In self refresh, the first edge with the clock-enable high again gives 4 (exit).
- R4: `bank_open[i]` is the bank whose BA value is i. Activate sets the bit for bank BA. Precharge with addr[10]=0 clears only bank BA. Precharge with addr[10]=1 gives code 10 and clears all banks whatever BA holds.
- R5: A read or write with addr[10]=1 requests auto-precharge and gives code 12 for a read or 13 for a write.
- R6: A read or write of any kind to a closed bank sets `err_sticky[3]`. An activate to an already open bank sets `err_sticky[4]`.
- R7: A mode write, an auto refresh or a self refresh entry while any bank is open sets `err_sticky[0]`.
- R8: A command other than a no-op (code 0 or 11) at either of the two edges after a mode write sets `err_sticky[1]`. The third edge is free.
- R9: A mode write captures the burst length from addr[2:0]: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. Any other value gives 1.
- R10: After an auto-precharge read or write at edge k with burst length BL, a read or write at edges k+1 to k+BL-1 sets `err_sticky[2]`. The bank is shown closed after edge k+BL-1, or at once when BL=1. A read or write to another open bank at edge k+BL is legal.
- R11: A burst stop during an auto-precharge burst ends that burst at once and closes its bank.
- R12: `err_pulse` is high for exactly the cycle after an edge that broke a rule. `err_sticky` bits stay set until reset.
- R13: `wr_en` is the inverse of `dqm` in the same cycle. `rd_oe` is low in the cycle that precedes edge k+2 when `dqm` was high at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address bus |
| cmd_q | output | 4 | Command code decoded at the last edge |
| bank_open | output | 4 | Open flag per bank |
| err_sticky | output | 5 | Sticky rule-violation vector |
| err_pulse | output | 1 | One-cycle violation pulse |
| rd_oe | output | 1 | Read data output enable after mask latency |
| wr_en | output | 1 | Write byte enable, same cycle as the mask |

## Verification
The hardest case to reach is the auto-precharge window. To get there, the bench must first write a burst length of four or eight, wait out the quiet gap and open two banks. Only then can it issue the auto-precharge read and land a read on the other bank at a chosen edge inside or just past the window. Each such sequence starts from a fresh reset. Every edge is one directed call, so the violating edge and the first legal edge (k+BL-1 and k+BL) can be placed exactly, and so can the burst stop that cuts the window short.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_MRS      = 4'd1,
        CMD_AREF     = 4'd2,
        CMD_SREF_IN  = 4'd3,
        CMD_SREF_OUT = 4'd4,
        CMD_ACT      = 4'd5,
        CMD_RD       = 4'd6,
        CMD_WR       = 4'd7,
        CMD_BST      = 4'd8,
        CMD_PRE      = 4'd9,
        CMD_PREA     = 4'd10,
        CMD_HOLD     = 4'd11,
        CMD_RDA      = 4'd12,
        CMD_WRA      = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_MRS_WAIT = 2'd1,
        ST_AP_BURST = 2'd2,
        ST_SELF_REF = 2'd3
    } seq_st_e;

    localparam int ERR_W      = 5;
    localparam int E_NOT_IDLE = 0;
    localparam int E_MRS_GAP  = 1;
    localparam int E_AP_BUSY  = 2;
    localparam int E_CLOSED   = 3;
    localparam int E_REOPEN   = 4;

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

    function automatic logic is_auto_pre(input cmd_e c);
        return (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap_flag,
    input  logic in_sref,
    output cmd_e cmd
);

    logic cke_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= cke;
    end

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            // previous edge had the clock held: pins carry no command
            cmd = (cke && in_sref) ? CMD_SREF_OUT : CMD_HOLD;
        end else if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = CMD_MRS;
                3'b001: cmd = cke ? CMD_AREF : CMD_SREF_IN;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = ap_flag ? CMD_RDA : CMD_RD;
                3'b100: cmd = ap_flag ? CMD_WRA : CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = ap_flag ? CMD_PREA : CMD_PRE;
                3'b111: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cmd_e                    cmd,
    input  logic [BA_W-1:0]         ba,
    input  logic                    ap_close,
    input  logic [BA_W-1:0]         ap_bank,
    output logic [(1<<BA_W)-1:0]    bank_open,
    output logic                    err_not_idle,
    output logic                    err_closed,
    output logic                    err_reopen
);

    localparam int NUM_BANKS = 1 << BA_W;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        logic shut;
        assign hit  = (ba == BA_W'(i));
        assign shut = (cmd == CMD_PREA) ||
                      ((cmd == CMD_PRE) && hit) ||
                      (ap_close && (ap_bank == BA_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n)                      bank_open[i] <= 1'b0;
            else if ((cmd == CMD_ACT) && hit) bank_open[i] <= 1'b1;
            else if (shut)                   bank_open[i] <= 1'b0;
        end
    end

    always_comb begin
        err_closed   = is_column(cmd) && !bank_open[ba];
        err_reopen   = (cmd == CMD_ACT) && bank_open[ba];
        err_not_idle = ((cmd == CMD_MRS) || (cmd == CMD_AREF) || (cmd == CMD_SREF_IN))
                       && (|bank_open);
    end

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_mon_pkg::*;
#(
    parameter int BA_W    = 2,
    parameter int MRS_GAP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic [2:0]      bl_code,
    output logic            in_sref,
    output logic            ap_close,
    output logic [BA_W-1:0] ap_bank,
    output logic            err_gap,
    output logic            err_busy
);

    localparam int MAX_BL = 8;
    localparam int CNT_W  = $clog2(((MRS_GAP > MAX_BL) ? MRS_GAP : MAX_BL) + 1);

    function automatic logic [CNT_W-1:0] burst_len(input logic [2:0] code);
        case (code)
            3'b001:  return CNT_W'(2);
            3'b010:  return CNT_W'(4);
            3'b011:  return CNT_W'(8);
            default: return CNT_W'(1);
        endcase
    endfunction

    seq_st_e           state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [CNT_W-1:0]  bl, bl_n;
    logic [BA_W-1:0]   bank_q, bank_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_READY;
            cnt    <= '0;
            bl     <= CNT_W'(1);
            bank_q <= '0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            bl     <= bl_n;
            bank_q <= bank_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        bank_n   = bank_q;
        bl_n     = (cmd == CMD_MRS) ? burst_len(bl_code) : bl;
        ap_close = 1'b0;
        ap_bank  = (state == ST_AP_BURST) ? bank_q : ba;
        err_gap  = 1'b0;
        err_busy = 1'b0;
        in_sref  = (state == ST_SELF_REF);

        unique case (state)
            ST_READY: begin
                if (cmd == CMD_MRS) begin
                    state_n = ST_MRS_WAIT;
                    cnt_n   = CNT_W'(MRS_GAP);
                end else if (cmd == CMD_SREF_IN) begin
                    state_n = ST_SELF_REF;
                end else if (is_auto_pre(cmd)) begin
                    if (bl == CNT_W'(1)) begin
                        ap_close = 1'b1;
                    end else begin
                        state_n = ST_AP_BURST;
                        cnt_n   = bl - CNT_W'(1);
                        bank_n  = ba;
                    end
                end
            end
            ST_MRS_WAIT: begin
                if ((cmd != CMD_NOP) && (cmd != CMD_HOLD)) err_gap = 1'b1;
                cnt_n = cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) state_n = ST_READY;
            end
            ST_AP_BURST: begin
                if (is_column(cmd)) err_busy = 1'b1;
                if ((cmd == CMD_BST) || (cnt == CNT_W'(1))) begin
                    state_n  = ST_READY;
                    ap_close = 1'b1;
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            ST_SELF_REF: begin
                if (cmd == CMD_SREF_OUT) state_n = ST_READY;
            end
        endcase
    end

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic rd_oe,
    output logic wr_en
);

    logic tap [RD_LAT+1];

    assign tap[0] = dqm;

    for (genvar i = 0; i < RD_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) tap[i+1] <= 1'b0;
            else        tap[i+1] <= tap[i];
        end
    end

    assign rd_oe = ~tap[RD_LAT];
    assign wr_en = ~dqm;

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BA_W    = 2,
    parameter int ADDR_W  = 12,
    parameter int AP_BIT  = 10,
    parameter int MRS_GAP = 2,
    parameter int RD_LAT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic                    dqm,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    output logic [3:0]              cmd_q,
    output logic [(1<<BA_W)-1:0]    bank_open,
    output logic [ERR_W-1:0]        err_sticky,
    output logic                    err_pulse,
    output logic                    rd_oe,
    output logic                    wr_en
);

    localparam logic [ADDR_W-1:0] USED_MASK = (ADDR_W'(1) << AP_BIT) | ADDR_W'(7);

    cmd_e             cmd;
    logic             in_sref;
    logic             ap_close;
    logic [BA_W-1:0]  ap_bank;
    logic             err_not_idle, err_closed, err_reopen, err_gap, err_busy;
    logic [ERR_W-1:0] err_now;
    logic             unused_addr;

    assign unused_addr = ^(addr & ~USED_MASK);

    sdram_cmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ap_flag (addr[AP_BIT]),
        .in_sref (in_sref),
        .cmd     (cmd)
    );

    sdram_bank_tracker #(.BA_W(BA_W)) u_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .ba           (ba),
        .ap_close     (ap_close),
        .ap_bank      (ap_bank),
        .bank_open    (bank_open),
        .err_not_idle (err_not_idle),
        .err_closed   (err_closed),
        .err_reopen   (err_reopen)
    );

    sdram_seq_fsm #(.BA_W(BA_W), .MRS_GAP(MRS_GAP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ba       (ba),
        .bl_code  (addr[2:0]),
        .in_sref  (in_sref),
        .ap_close (ap_close),
        .ap_bank  (ap_bank),
        .err_gap  (err_gap),
        .err_busy (err_busy)
    );

    sdram_dqm_pipe #(.RD_LAT(RD_LAT)) u_dqm (
        .clk   (clk),
        .rst_n (rst_n),
        .dqm   (dqm),
        .rd_oe (rd_oe),
        .wr_en (wr_en)
    );

    always_comb begin
        err_now             = '0;
        err_now[E_NOT_IDLE] = err_not_idle;
        err_now[E_MRS_GAP]  = err_gap;
        err_now[E_AP_BUSY]  = err_busy;
        err_now[E_CLOSED]   = err_closed;
        err_now[E_REOPEN]   = err_reopen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NOP;
            err_sticky <= '0;
            err_pulse  <= 1'b0;
        end else begin
            cmd_q      <= cmd;
            err_sticky <= err_sticky | err_now;
            err_pulse  <= |err_now;
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dqm,
    input logic [1:0]       ba,
    input logic [3:0]       cmd_q,
    input logic [3:0]       bank_open,
    input logic [ERR_W-1:0] err_sticky,
    input logic             err_pulse,
    input logic             rd_oe
);

    logic [1:0] cyc;
    logic [1:0] ba_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc  <= 2'd0;
            ba_d <= 2'd0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
            ba_d <= ba;
        end
    end

    p_sticky_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) |-> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    p_pulse_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_sticky != '0));

    p_read_mask_lat_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (rd_oe == !$past(dqm, 2)));

    p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc != 2'd0) && (cmd_q == CMD_ACT)) |-> bank_open[ba_d]);

    p_prea_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PREA) |-> (bank_open == 4'b0000));

    p_mode_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc != 2'd0) && (cmd_q == CMD_MRS) && ($past(bank_open) != 4'b0000))
        |-> err_sticky[E_NOT_IDLE]);

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dqm        (dqm),
    .ba         (ba),
    .cmd_q      (cmd_q),
    .bank_open  (bank_open),
    .err_sticky (err_sticky),
    .err_pulse  (err_pulse),
    .rd_oe      (rd_oe)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        dqm = 1'b0;
    logic [1:0]  ba = 2'd0;
    logic [11:0] addr = 12'd0;
    logic [3:0]  cmd_q;
    logic [3:0]  bank_open;
    logic [4:0]  err_sticky;
    logic        err_pulse, rd_oe, wr_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr),
        .cmd_q(cmd_q), .bank_open(bank_open), .err_sticky(err_sticky),
        .err_pulse(err_pulse), .rd_oe(rd_oe), .wr_en(wr_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drv(input logic k, input logic c, input logic r, input logic a,
                       input logic w, input logic [1:0] b, input logic [11:0] ad);
        cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();                     drv(1, 0, 1, 1, 1, 2'd0, 12'h000); endtask
    task automatic act(input logic [1:0] b);  drv(1, 0, 0, 1, 1, b, 12'h155); endtask
    task automatic rd(input logic [1:0] b, input logic ap);
        drv(1, 0, 1, 0, 1, b, ap ? 12'h410 : 12'h010);
    endtask
    task automatic wr(input logic [1:0] b, input logic ap);
        drv(1, 0, 1, 0, 0, b, ap ? 12'h420 : 12'h020);
    endtask
    task automatic pre(input logic [1:0] b);  drv(1, 0, 0, 1, 0, b, 12'h000); endtask
    task automatic prea(input logic [1:0] b); drv(1, 0, 0, 1, 0, b, 12'h400); endtask
    task automatic mrs(input logic [2:0] c);  drv(1, 0, 0, 0, 0, 2'd0, {9'd0, c}); endtask
    task automatic aref();                    drv(1, 0, 0, 0, 1, 2'd0, 12'h000); endtask
    task automatic sref_in();                 drv(0, 0, 0, 0, 1, 2'd0, 12'h000); endtask
    task automatic bst();                     drv(1, 0, 1, 1, 0, 2'd0, 12'h000); endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; dqm = 0; ba = 0; addr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        reset_dut();
        chk("R1 cmd", cmd_q, 0);
        chk("R1 banks", bank_open, 0);
        chk("R1 sticky", err_sticky, 0);
        chk("R1 pulse", err_pulse, 0);
        chk("R1 rd_oe", rd_oe, 1);
    endtask

    task automatic t_decode();
        reset_dut();
        act(2);   chk("R2 act code", cmd_q, 5); chk("R4 act opens", bank_open, 4'b0100);
        rd(2, 0); chk("R2 read code", cmd_q, 6);
        wr(2, 0); chk("R2 write code", cmd_q, 7);
        bst();    chk("R2 burst stop code", cmd_q, 8);
        nop();    chk("R2 nop code", cmd_q, 0);
        drv(1, 1, 0, 1, 1, 2'd1, 12'h000);
        chk("R2 deselect code", cmd_q, 0); chk("R2 deselect no open", bank_open, 4'b0100);
        pre(2);   chk("R2 precharge code", cmd_q, 9); chk("R4 pre closes", bank_open, 0);
        chk("R2 no error", err_sticky, 0);
    endtask

    task automatic t_precharge();
        reset_dut();
        act(0); act(3); act(1);
        pre(3);  chk("R4 single bank close", bank_open, 4'b0011);
        prea(1); chk("R4 all-bank code", cmd_q, 10); chk("R4 all closed", bank_open, 0);
    endtask

    task automatic t_column_errors();
        reset_dut();
        rd(1, 0); chk("R6 closed read", err_sticky, 5'b01000); chk("R12 pulse high", err_pulse, 1);
        nop();    chk("R12 pulse drops", err_pulse, 0); chk("R12 sticky holds", err_sticky, 5'b01000);
        act(1); act(1);
        chk("R6 reopen", err_sticky, 5'b11000);
    endtask

    task automatic t_idle_rules();
        reset_dut();
        act(0); mrs(3'b000); chk("R7 mode with open bank", err_sticky, 5'b00001);
        reset_dut();
        act(0); aref(); chk("R3 aref code", cmd_q, 2); chk("R7 aref with open bank", err_sticky, 5'b00001);
        reset_dut();
        aref(); chk("R7 aref idle ok", err_sticky, 0);
        reset_dut();
        act(3); sref_in(); chk("R3 sref entry code", cmd_q, 3); chk("R7 sref with open bank", err_sticky, 5'b00001);
    endtask

    task automatic t_mode_gap();
        reset_dut();
        mrs(3'b000); chk("R2 mode code", cmd_q, 1);
        nop(); act(0); chk("R8 second edge busy", err_sticky, 5'b00010);
        reset_dut();
        mrs(3'b000); act(0); chk("R8 first edge busy", err_sticky, 5'b00010);
        reset_dut();
        mrs(3'b000); nop(); nop(); act(0);
        chk("R8 third edge free", err_sticky, 0); chk("R8 third edge opens", bank_open, 4'b0001);
    endtask

    task automatic t_auto_pre();
        reset_dut();
        act(1); wr(1, 1);
        chk("R5 write ap code", cmd_q, 13); chk("R9 default length closes at once", bank_open, 0);
        chk("R9 default no error", err_sticky, 0);
        reset_dut();
        mrs(3'b010); nop(); nop(); act(0); act(1);
        rd(0, 1); chk("R5 read ap code", cmd_q, 12);
        nop(); nop(); chk("R10 bank open mid burst", bank_open, 4'b0011);
        nop(); chk("R10 bank closed at last edge", bank_open, 4'b0010);
        rd(1, 0); chk("R10 other bank after burst", err_sticky, 0);
        reset_dut();
        mrs(3'b010); nop(); nop(); act(0); act(1);
        rd(0, 1); nop(); nop(); rd(1, 0);
        chk("R10 read inside burst", err_sticky, 5'b00100);
        reset_dut();
        mrs(3'b011); nop(); nop(); act(0); act(1);
        rd(0, 1); repeat (6) nop(); rd(1, 0);
        chk("R9 length 8 window", err_sticky, 5'b00100);
    endtask

    task automatic t_burst_stop();
        reset_dut();
        mrs(3'b011); nop(); nop(); act(0); act(1);
        rd(0, 1); nop(); bst();
        chk("R11 stop code", cmd_q, 8); chk("R11 bank closed", bank_open, 4'b0010);
        rd(1, 0); chk("R11 read after stop", err_sticky, 0);
    endtask

    task automatic t_self_refresh();
        reset_dut();
        sref_in(); chk("R3 entry code", cmd_q, 3);
        drv(0, 0, 0, 1, 1, 2'd2, 12'h000);
        chk("R3 held clock code", cmd_q, 11); chk("R3 held ignores act", bank_open, 0);
        drv(1, 1, 1, 1, 1, 2'd0, 12'h000); chk("R3 exit code", cmd_q, 4);
        act(2); chk("R3 active after exit", bank_open, 4'b0100);
        chk("R3 no error", err_sticky, 0);
    endtask

    task automatic t_dqm();
        reset_dut();
        dqm = 1'b1; #1;
        chk("R13 write mask same cycle", wr_en, 0);
        nop();
        dqm = 1'b0; #1;
        chk("R13 write enable restored", wr_en, 1);
        chk("R13 read oe after one edge", rd_oe, 1);
        nop(); chk("R13 read oe off before edge k+2", rd_oe, 0);
        nop(); chk("R13 read oe back", rd_oe, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_precharge();
        t_column_errors();
        t_idle_rules();
        t_mode_gap();
        t_auto_pre();
        t_burst_stop();
        t_self_refresh();
        t_dqm();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule